// File: doc/BRIEF.md
# Timer Input Capture Unit

This block timestamps transitions on an external signal. The signal arrives with no relation to the local clock, so it first passes through a two-stage synchronizer. A transition of the polarity chosen in a 2-bit control field then copies the full 16-bit value of a free-running counter into a capture register in one transfer. A flag output goes high on every completed transfer and stays high until software clears it.

Software reads the 16-bit timestamp over an 8-bit bus, one byte per bus cycle, with the upper byte first. A read of the upper byte freezes the capture register for that bus cycle and for the next one. The lower byte read in the next cycle therefore always belongs to the same capture. An edge that arrives while the register is frozen is not lost. The counter value at that edge is parked in a shadow latch and copied into the capture register in the first cycle that is not frozen.

Top module: `ticap_unit`

## Requirements
- R1: After reset the counter is 0. It increments by one on every clock and wraps from 16'hFFFF to 16'h0000.
- R2: Suppose a selected pin change meets setup before clock edge P and the capture register is not frozen. The capture register then receives the counter value held between edges P+1 and P+2, and it is readable after edge P+2.
- R3: Bits [1:0] at bus address 2 select the edge mode: 00 = disabled, 01 = rising only, 10 = falling only, 11 = both edges. The field reads back at address 2 and resets to 00.
- R4: With mode 00, pin changes produce no capture and do not set the flag.
- R5: During a read cycle, bus_rdata shows the upper capture byte at address 0 and the lower capture byte at address 1 in that same cycle.
- R6: Writes to addresses 0 and 1 leave the captured value unchanged.
- R7: A read of address 0 blocks transfers in its own cycle and in the next cycle. An edge detected in a blocked cycle is transferred at the end of the first unblocked cycle, with the counter value from the cycle in which the edge was detected.
- R8: Reading address 0 and then address 1 in back-to-back cycles returns both bytes of one capture, even when an edge is detected during those two cycles.
- R9: While a deferred capture is pending, further edges are dropped, and the first value is the one transferred.
- R10: cap_flag (also bit 0 at address 3) goes high at the clock edge that completes a transfer. Writing 1 to bit 0 at address 3 clears it. Writing 0 there has no effect. The flag resets to 0.
- R11: Reset does not clear the capture register. A value captured before reset still reads back after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_pin | input | 1 | Asynchronous signal to be timestamped |
| bus_sel | input | 1 | Bus cycle valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| cap_flag | output | 1 | Capture-complete flag |

## Verification
An unblocked capture is due three clock edges after the pin changes: two synchronizer stages and then the transfer. The captured value equals the counter during the cycle after the second stage. The bench keeps a reset-aligned counter model and samples that model in the detect cycle to form the expected timestamp. For deferred captures, it counts the blocked cycles explicitly and checks that the flag is still low in each cycle before the transfer is due and high in the cycle after. Read data is combinational, so every bus result is sampled one nanosecond after the negative edge at which the address was driven.

// File: rtl/ticap_pkg.sv
package ticap_pkg;
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    localparam int unsigned ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_CAP_HI = 2'd0;
    localparam logic [ADDR_W-1:0] A_CAP_LO = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT   = 2'd3;
endpackage

// File: rtl/ticap_counter.sv
module ticap_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_q
);
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/ticap_edge.sv
module ticap_edge
    import ticap_pkg::*;
#(
    parameter int unsigned SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  edge_mode_e mode,
    output logic       hit
);
    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic              prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     lvl, rise, fall;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_N-2:0], pin};
        lvl       = st_q.sync[SYNC_N-1];
        st_d.prev = lvl;
        rise      = lvl & ~st_q.prev;
        fall      = ~lvl & st_q.prev;
        unique case (mode)
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == EDGE_OFF) |-> !hit);
endmodule

// File: rtl/ticap_latch.sv
module ticap_latch #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             blk,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap_q,
    output logic             xfer
);
    typedef struct packed {
        logic [CNT_W-1:0] cap;
        logic [CNT_W-1:0] shadow;
    } data_st_t;

    data_st_t dat_d, dat_q;
    logic     pend_d, pend_q;

    always_comb begin
        dat_d  = dat_q;
        pend_d = pend_q;
        xfer   = 1'b0;
        if (blk) begin
            if (hit && !pend_q) begin
                pend_d       = 1'b1;
                dat_d.shadow = cnt;
            end
        end else if (pend_q) begin
            dat_d.cap = dat_q.shadow;
            pend_d    = 1'b0;
            xfer      = 1'b1;
        end else if (hit) begin
            dat_d.cap = cnt;
            xfer      = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    always_ff @(posedge clk) begin
        dat_q <= dat_d;
    end

    assign cap_q = dat_q.cap;

    assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blk |=> $stable(cap_q));
    assert_pend_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !blk) |=> !pend_q);
    assert_first_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |=> $stable(dat_q.shadow));
endmodule

// File: rtl/ticap_unit.sv
module ticap_unit
    import ticap_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_pin,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              cap_flag
);
    localparam int unsigned BUS_W = CNT_W / 2;

    typedef struct packed {
        edge_mode_e mode;
        logic       flag;
        logic       hold;
    } ctl_st_t;

    ctl_st_t          st_d, st_q;
    logic [CNT_W-1:0] cnt, cap;
    logic             hit, xfer, blk, hi_rd, wr_ctrl, wr_stat;
    logic             unused_wdata;

    ticap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt_q(cnt)
    );

    ticap_edge #(.SYNC_N(SYNC_N)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin(cap_pin), .mode(st_q.mode), .hit(hit)
    );

    ticap_latch #(.CNT_W(CNT_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .hit(hit), .blk(blk), .cnt(cnt),
        .cap_q(cap), .xfer(xfer)
    );

    assign unused_wdata = ^bus_wdata[7:2];

    always_comb begin
        st_d    = st_q;
        hi_rd   = bus_sel && !bus_wr && (bus_addr == A_CAP_HI);
        wr_ctrl = bus_sel && bus_wr && (bus_addr == A_CTRL);
        wr_stat = bus_sel && bus_wr && (bus_addr == A_STAT);
        blk     = hi_rd || st_q.hold;
        st_d.hold = hi_rd;
        if (wr_ctrl) st_d.mode = edge_mode_e'(bus_wdata[1:0]);
        if (xfer)                       st_d.flag = 1'b1;
        else if (wr_stat && bus_wdata[0]) st_d.flag = 1'b0;
        unique case (bus_addr)
            A_CAP_HI: bus_rdata = cap[CNT_W-1 -: BUS_W];
            A_CAP_LO: bus_rdata = cap[BUS_W-1:0];
            A_CTRL:   bus_rdata = {6'b0, st_q.mode};
            default:  bus_rdata = {7'b0, st_q.flag};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= EDGE_OFF;
            st_q.flag <= 1'b0;
            st_q.hold <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_flag = st_q.flag;

    assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> cap_flag);
    assert_pair_coherent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hi_rd |=> $stable(cap));
endmodule

// File: tb/sim_ticap_unit.sv
module sim_ticap_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cap_pin = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       cap_flag;
    logic [15:0] bc;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    ticap_unit u0 (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cap_flag(cap_flag)
    );

    always #5 clk = ~clk;

    // counter model: 0 in reset, +1 per clock
    always @(posedge clk) begin
        if (!rst_n) bc <= 16'd0;
        else        bc <= bc + 16'd1;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_op();
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic pin_op(input logic v);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; cap_pin = v;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic read_cap(output logic [15:0] v);
        logic [7:0] h, l;
        rd(2'd0, h);
        rd(2'd1, l);
        idle_op();
        v = {h, l};
    endtask

    task automatic edge_capture(input logic v, output logic [15:0] exp);
        pin_op(v);
        idle_op();
        idle_op();
        exp = bc;
        idle_op();
    endtask

    task automatic clear_flag();
        wr(2'd3, 8'h01);
        idle_op();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(2'd2, d); chk("R3 mode reset", 16'(d), 16'h0000);
        rd(2'd3, d); chk("R10 flag reset", 16'(d), 16'h0000);
        chk("R10 flag pin reset", 16'(cap_flag), 16'h0000);
    endtask

    task automatic t_rise();
        logic [15:0] exp, got;
        logic [7:0] d;
        wr(2'd2, 8'h01);
        rd(2'd2, d); chk("R3 mode readback", 16'(d), 16'h0001);
        edge_capture(1'b1, exp);
        chk("R10 flag after capture", 16'(cap_flag), 16'h0001);
        read_cap(got);
        chk("R2 R5 rising capture", got, exp);
    endtask

    task automatic t_flag();
        logic [7:0] d;
        wr(2'd3, 8'h00); idle_op();
        chk("R10 write zero keeps flag", 16'(cap_flag), 16'h0001);
        wr(2'd3, 8'h01); idle_op();
        chk("R10 w1c clears flag", 16'(cap_flag), 16'h0000);
        rd(2'd3, d); chk("R10 status read", 16'(d), 16'h0000);
    endtask

    task automatic t_fall();
        logic [15:0] exp, got, keep;
        wr(2'd2, 8'h02);
        edge_capture(1'b0, exp);
        read_cap(got);
        chk("R3 falling capture", got, exp);
        clear_flag();
        keep = got;
        edge_capture(1'b1, exp);
        repeat (2) idle_op();
        chk("R3 rise ignored in fall mode flag", 16'(cap_flag), 16'h0000);
        read_cap(got);
        chk("R3 rise ignored in fall mode value", got, keep);
    endtask

    task automatic t_both();
        logic [15:0] exp, got;
        wr(2'd2, 8'h03);
        edge_capture(1'b0, exp);
        read_cap(got); chk("R3 both mode falling", got, exp);
        edge_capture(1'b1, exp);
        read_cap(got); chk("R3 both mode rising", got, exp);
    endtask

    task automatic t_off();
        logic [15:0] keep, got, unused_e;
        read_cap(keep);
        wr(2'd2, 8'h00);
        clear_flag();
        edge_capture(1'b0, unused_e);
        edge_capture(1'b1, unused_e);
        repeat (2) idle_op();
        chk("R4 off mode flag", 16'(cap_flag), 16'h0000);
        read_cap(got); chk("R4 off mode value", got, keep);
    endtask

    task automatic t_write();
        logic [15:0] keep, got;
        read_cap(keep);
        wr(2'd0, ~keep[15:8]);
        wr(2'd1, ~keep[7:0]);
        idle_op();
        read_cap(got); chk("R6 writes ignored", got, keep);
    endtask

    task automatic t_coherent();
        logic [15:0] old, exp, got;
        logic [7:0] h, l;
        wr(2'd2, 8'h03);
        clear_flag();
        read_cap(old);
        pin_op(~cap_pin);
        idle_op();
        rd(2'd0, h); exp = bc;
        rd(2'd1, l);
        chk("R8 pair from one capture", {h, l}, old);
        idle_op(); #1;
        chk("R7 flag still low while deferred", 16'(cap_flag), 16'h0000);
        idle_op(); #1;
        chk("R7 flag after deferred transfer", 16'(cap_flag), 16'h0001);
        read_cap(got); chk("R7 deferred value from edge", got, exp);
    endtask

    task automatic t_defer();
        logic [15:0] exp, got;
        logic [7:0] h;
        clear_flag();
        pin_op(~cap_pin);
        rd(2'd0, h);
        idle_op(); exp = bc; #1;
        chk("R7 no transfer in hold cycle", 16'(cap_flag), 16'h0000);
        idle_op(); #1;
        chk("R7 transfer not yet visible", 16'(cap_flag), 16'h0000);
        idle_op(); #1;
        chk("R7 transfer after hold", 16'(cap_flag), 16'h0001);
        read_cap(got); chk("R7 hold-cycle value kept", got, exp);
    endtask

    task automatic t_drop();
        logic [15:0] exp, got;
        logic [7:0] h;
        logic p;
        clear_flag();
        p = cap_pin;
        pin_op(~p);
        pin_op(p);
        rd(2'd0, h); exp = bc;
        idle_op(); idle_op(); idle_op();
        read_cap(got); chk("R9 first pending value kept", got, exp);
        clear_flag();
        repeat (4) idle_op();
        chk("R9 second edge dropped", 16'(cap_flag), 16'h0000);
        read_cap(got); chk("R9 value unchanged", got, exp);
    endtask

    task automatic t_reset_keep();
        logic [15:0] keep, got;
        logic [7:0] d;
        read_cap(keep);
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        read_cap(got); chk("R11 capture survives reset", got, keep);
        rd(2'd2, d); chk("R11 mode cleared by reset", 16'(d), 16'h0000);
    endtask

    task automatic t_wrap();
        logic [15:0] exp, got;
        wr(2'd2, 8'h01);
        pin_op(1'b0);
        repeat (4) idle_op();
        while (bc != 16'hFFFD) idle_op();
        edge_capture(1'b1, exp);
        read_cap(got); chk("R1 counter wraps to zero", got, 16'h0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_rise();
        t_flag();
        t_fall();
        t_both();
        t_off();
        t_write();
        t_coherent();
        t_defer();
        t_drop();
        t_reset_keep();
        t_wrap();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule